// File: doc/BRIEF.md
# SD Card SPI Single-Sector Writer

This block is an SPI-mode master that stores one 512-byte sector on an SD card. A start pulse latches a 32-bit sector number. The block then waits until the card reports ready and sends the single-block write command with the sector number as its argument. It checks the card's first response byte, sends a start token and the sector data, and reads the card's data-response token. If the card accepts the data, the block waits until the card is no longer busy. It ends every operation with one idle byte of clocks while chip select is high.

The sector data comes from an external buffer through a word-read port. The block fetches 128 words of 32 bits each, one per read, in ascending word index. The buffer answers one cycle after the read request. Each word holds four bytes in little-endian order, and the least significant byte goes on the wire first. A busy/done/error handshake reports the result. An 8-bit code tells apart the ways an operation can fail, and a timeout bounds the whole operation.

Top module: `sd_block_writer`

## Requirements
- R1: After reset, and whenever no operation is running, `csN`, `sck` and `mosi` are high and `busy` is low. A `start` pulse while idle raises `busy` and lowers `csN`.
- R2: One SCK period lasts `CLK_DIV` system cycles (default 12). Bytes go out most significant bit first. MOSI changes only when SCK falls, never in the cycle where SCK rises. MISO is sampled on the rising edge, and 0xFF is driven on MOSI whenever the block only receives.
- R3: Before the command, the block sends 0xFF bytes until it receives 0xFF (card ready).
- R4: The command frame is the six bytes 0x58, sector[31:24], sector[23:16], sector[15:8], sector[7:0], 0x01.
- R5: The R1 response is the first received byte with bit 7 clear, searched over at most 8 bytes. A nonzero R1 fails with `errCode` equal to the R1 value. If no such byte arrives in 8 bytes, the operation fails with `errCode` 0x80.
- R6: After R1 = 0x00, the block sends 0xFE, then 512 data bytes, then two 0xFF bytes in place of a CRC. Word w is read at `bufAddr` = w. Its bytes go out in the order bits [7:0], [15:8], [23:16], [31:24].
- R7: The next received byte, masked to its low five bits, must equal 0b00101. Any other value fails with `errCode` = 0xA0 OR the masked value.
- R8: After an accepted response, the block keeps `csN` low and clocks 0xFF bytes until the card returns 0xFF.
- R9: Every operation ends by raising `csN` and then clocking one 0xFF byte (8 SCK pulses) with `csN` high. After that, `done` pulses for one cycle, `busy` falls in that same cycle, and `error` pulses with `done` only on failure. On success `errCode` is 0x00.
- R10: If `TIMEOUT_CYCLES` have passed since start while the block waits for ready or for not-busy, the operation fails with `errCode` 0xC0.
- R11: A `start` pulse while `busy` is high is ignored. The bytes on the wire and the result belong to the running operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sector write (accepted when idle) |
| sector | input | 32 | Sector number, latched at start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Failure flag, pulses with done |
| errCode | output | 8 | Result code of the last operation |
| bufRdEn | output | 1 | Buffer read request |
| bufAddr | output | 7 | Word index into the sector buffer |
| bufRdData | input | 32 | Buffer word, valid the cycle after the request |
| sck | output | 1 | SPI clock, idles high |
| mosi | output | 1 | SPI data to the card |
| miso | input | 1 | SPI data from the card |
| csN | output | 1 | Card select, active low |

## Verification
The bench drives a card model that answers byte by byte from a script, so each decision point can be forced. The scripts cover a card that is not ready on its first poll, an R1 that arrives in the second slot, a nonzero R1, an R1 that never comes, a data response whose upper bits are set but whose low five bits are accepted, a rejected data response, a card that stays busy for several bytes, and a card stuck low until the timeout.

Each case targets a specific fault. A design that skipped the ready poll, masked the response wrongly, or sent word bytes in the wrong order would put bytes on MOSI that the scoreboard flags. A design that raised CS during the busy wait would leave expected bytes unconsumed. A start pulse in the middle of a transfer would change the stream if the design did not ignore it. A wrong SCK period, or MOSI moving on a rising edge, is caught edge by edge.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

  typedef struct packed {
    logic       start;
    logic [7:0] txByte;
  } shiftCmd_t;

  localparam logic [7:0] CMD_WRITE_ONE = 8'h58;
  localparam logic [7:0] CMD_CRC_DUMMY = 8'h01;
  localparam logic [7:0] TOKEN_START   = 8'hFE;
  localparam logic [7:0] IDLE_BYTE     = 8'hFF;
  localparam logic [4:0] DRESP_OK      = 5'b00101;

  localparam logic [7:0] ERR_NONE       = 8'h00;
  localparam logic [7:0] ERR_NO_R1      = 8'h80;
  localparam logic [7:0] ERR_DRESP_BASE = 8'hA0;
  localparam logic [7:0] ERR_TIMEOUT    = 8'hC0;

  typedef enum logic [3:0] {
    S_IDLE, S_POLL, S_CMD, S_R1, S_TOKEN, S_LOAD, S_LATCH,
    S_DATA, S_CRC, S_RESP, S_BUSYWAIT, S_TAIL, S_FINISH
  } wrState_t;

endpackage

// File: rtl/sdw_timer.sv
module sdw_timer #(
  parameter int unsigned LIMIT = 200_000_000,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic arm,
  input  logic run,
  output logic expired
);

  logic [W-1:0] count;
  logic         expReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      expReg <= 1'b0;
    end else if (arm) begin
      count  <= '0;
      expReg <= 1'b0;
    end else if (run && !expReg) begin
      if (count == W'(LIMIT - 1)) expReg <= 1'b1;
      else                        count  <= count + 1'b1;
    end
  end

  assign expired = expReg;

  // R10: once expired, the flag stays until the next operation is armed
  p_expiry_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    expired && !arm |=> expired);

endmodule

// File: rtl/sdw_shifter.sv
module sdw_shifter import sdw_pkg::*; #(
  parameter int CLK_DIV = 12,
  localparam int HALF  = CLK_DIV / 2,
  localparam int DIV_W = $clog2(HALF + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  shiftCmd_t  cmd,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       active,
  output logic       done,
  output logic [7:0] rxByte
);

  logic [DIV_W-1:0] divCnt;
  logic [2:0]       bitCnt;
  logic             phaseHigh;
  logic [7:0]       txSh;
  logic [7:0]       rxSh;
  logic             sckReg, mosiReg, activeReg, doneReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt    <= '0;
      bitCnt    <= '0;
      phaseHigh <= 1'b0;
      txSh      <= '0;
      rxSh      <= '0;
      sckReg    <= 1'b1;
      mosiReg   <= 1'b1;
      activeReg <= 1'b0;
      doneReg   <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      if (!activeReg) begin
        if (cmd.start) begin
          activeReg <= 1'b1;
          sckReg    <= 1'b0;
          mosiReg   <= cmd.txByte[7];
          txSh      <= {cmd.txByte[6:0], 1'b0};
          bitCnt    <= '0;
          phaseHigh <= 1'b0;
          divCnt    <= '0;
        end
      end else if (divCnt == DIV_W'(HALF - 1)) begin
        divCnt <= '0;
        if (!phaseHigh) begin
          sckReg    <= 1'b1;
          rxSh      <= {rxSh[6:0], miso};
          phaseHigh <= 1'b1;
        end else if (bitCnt == 3'd7) begin
          activeReg <= 1'b0;
          doneReg   <= 1'b1;
          mosiReg   <= 1'b1;
        end else begin
          bitCnt    <= bitCnt + 1'b1;
          sckReg    <= 1'b0;
          mosiReg   <= txSh[7];
          txSh      <= {txSh[6:0], 1'b0};
          phaseHigh <= 1'b0;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign sck    = sckReg;
  assign mosi   = mosiReg;
  assign active = activeReg;
  assign done   = doneReg;
  assign rxByte = rxSh;

  p_idle_clock_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> sck && mosi);

  p_mosi_holds_on_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sck) |-> $stable(mosi));

  p_start_only_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.start |-> !active);

  p_done_ends_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> sck && !active);

endmodule

// File: rtl/sdw_ctrl.sv
module sdw_ctrl import sdw_pkg::*; #(
  parameter int BLOCK_BYTES = 512,
  parameter int R1_TRIES    = 8,
  localparam int WORDS  = BLOCK_BYTES / 4,
  localparam int ADDR_W = $clog2(WORDS),
  localparam int CNT_W  = (R1_TRIES > 6) ? $clog2(R1_TRIES) : 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [31:0]       sector,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [7:0]        errCode,
  output logic              bufRdEn,
  output logic [ADDR_W-1:0] bufAddr,
  input  logic [31:0]       bufRdData,
  output logic              csN,
  output shiftCmd_t         shCmd,
  input  logic              shDone,
  input  logic [7:0]        shRx,
  input  logic              expired,
  output logic              timerArm
);

  wrState_t          state;
  logic              pending;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] wordIdx;
  logic [31:0]       wordReg;
  logic [31:0]       sectorReg;
  logic [7:0]        errReg;
  logic              busyReg, csReg, doneReg, errorReg, failed;
  logic [7:0]        txByte;
  logic              byteState;

  always_comb begin
    unique case (state)
      S_CMD: begin
        unique case (cnt)
          CNT_W'(0): txByte = CMD_WRITE_ONE;
          CNT_W'(1): txByte = sectorReg[31:24];
          CNT_W'(2): txByte = sectorReg[23:16];
          CNT_W'(3): txByte = sectorReg[15:8];
          CNT_W'(4): txByte = sectorReg[7:0];
          default:   txByte = CMD_CRC_DUMMY;
        endcase
      end
      S_TOKEN: txByte = TOKEN_START;
      S_DATA: begin
        unique case (cnt[1:0])
          2'd0:    txByte = wordReg[7:0];
          2'd1:    txByte = wordReg[15:8];
          2'd2:    txByte = wordReg[23:16];
          default: txByte = wordReg[31:24];
        endcase
      end
      default: txByte = IDLE_BYTE;
    endcase
  end

  assign byteState = state inside {S_POLL, S_CMD, S_R1, S_TOKEN, S_DATA,
                                   S_CRC, S_RESP, S_BUSYWAIT, S_TAIL};
  assign shCmd    = '{start: byteState && !pending, txByte: txByte};
  assign bufRdEn  = (state == S_LOAD);
  assign bufAddr  = wordIdx;
  assign timerArm = (state == S_IDLE) && start;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      pending   <= 1'b0;
      cnt       <= '0;
      wordIdx   <= '0;
      wordReg   <= '0;
      sectorReg <= '0;
      errReg    <= ERR_NONE;
      busyReg   <= 1'b0;
      csReg     <= 1'b1;
      doneReg   <= 1'b0;
      errorReg  <= 1'b0;
      failed    <= 1'b0;
    end else begin
      doneReg  <= 1'b0;
      errorReg <= 1'b0;
      if (shCmd.start)  pending <= 1'b1;
      else if (shDone)  pending <= 1'b0;

      unique case (state)
        S_IDLE: if (start) begin
          sectorReg <= sector;
          busyReg   <= 1'b1;
          csReg     <= 1'b0;
          failed    <= 1'b0;
          errReg    <= ERR_NONE;
          cnt       <= '0;
          state     <= S_POLL;
        end
        S_POLL: if (shDone) begin
          if (shRx == IDLE_BYTE) begin
            cnt   <= '0;
            state <= S_CMD;
          end else if (expired) begin
            errReg <= ERR_TIMEOUT; failed <= 1'b1; csReg <= 1'b1; state <= S_TAIL;
          end
        end
        S_CMD: if (shDone) begin
          if (cnt == CNT_W'(5)) begin
            cnt   <= '0;
            state <= S_R1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_R1: if (shDone) begin
          if (!shRx[7]) begin
            if (shRx == 8'h00) state <= S_TOKEN;
            else begin
              errReg <= shRx; failed <= 1'b1; csReg <= 1'b1; state <= S_TAIL;
            end
          end else if (cnt == CNT_W'(R1_TRIES - 1)) begin
            errReg <= ERR_NO_R1; failed <= 1'b1; csReg <= 1'b1; state <= S_TAIL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_TOKEN: if (shDone) begin
          wordIdx <= '0;
          state   <= S_LOAD;
        end
        S_LOAD: state <= S_LATCH;
        S_LATCH: begin
          wordReg <= bufRdData;
          cnt     <= '0;
          state   <= S_DATA;
        end
        S_DATA: if (shDone) begin
          if (cnt == CNT_W'(3)) begin
            cnt <= '0;
            if (wordIdx == ADDR_W'(WORDS - 1)) state <= S_CRC;
            else begin
              wordIdx <= wordIdx + 1'b1;
              state   <= S_LOAD;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_CRC: if (shDone) begin
          if (cnt == CNT_W'(1)) state <= S_RESP;
          else                  cnt   <= cnt + 1'b1;
        end
        S_RESP: if (shDone) begin
          if (shRx[4:0] == DRESP_OK) state <= S_BUSYWAIT;
          else begin
            errReg <= ERR_DRESP_BASE | {3'b000, shRx[4:0]};
            failed <= 1'b1; csReg <= 1'b1; state <= S_TAIL;
          end
        end
        S_BUSYWAIT: if (shDone) begin
          if (shRx == IDLE_BYTE) begin
            csReg <= 1'b1;
            state <= S_TAIL;
          end else if (expired) begin
            errReg <= ERR_TIMEOUT; failed <= 1'b1; csReg <= 1'b1; state <= S_TAIL;
          end
        end
        S_TAIL: if (shDone) state <= S_FINISH;
        S_FINISH: begin
          doneReg  <= 1'b1;
          errorReg <= failed;
          busyReg  <= 1'b0;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy    = busyReg;
  assign done    = doneReg;
  assign error   = errorReg;
  assign errCode = errReg;
  assign csN     = csReg;

  p_cs_high_when_free_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);

  p_busy_falls_with_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  p_done_drops_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_error_only_with_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);

  p_sector_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    busy && start |=> $stable(sectorReg));

  p_timeout_needs_expiry_r10: assert property (@(posedge clk) disable iff (!rstN)
    done && error && (errCode == ERR_TIMEOUT) |-> expired);

  p_read_outside_cs_r6: assert property (@(posedge clk) disable iff (!rstN)
    bufRdEn |-> !csN);

endmodule

// File: rtl/sd_block_writer.sv
module sd_block_writer import sdw_pkg::*; #(
  parameter int          CLK_DIV        = 12,
  parameter int unsigned TIMEOUT_CYCLES = 200_000_000,
  parameter int          BLOCK_BYTES    = 512,
  parameter int          R1_TRIES       = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               start,
  input  logic [31:0]                        sector,
  output logic                               busy,
  output logic                               done,
  output logic                               error,
  output logic [7:0]                         errCode,
  output logic                               bufRdEn,
  output logic [$clog2(BLOCK_BYTES/4)-1:0]   bufAddr,
  input  logic [31:0]                        bufRdData,
  output logic                               sck,
  output logic                               mosi,
  input  logic                               miso,
  output logic                               csN
);

  shiftCmd_t  shCmd;
  logic       shActive, shDone;
  logic [7:0] shRx;
  logic       expired, timerArm;

  sdw_ctrl #(
    .BLOCK_BYTES (BLOCK_BYTES),
    .R1_TRIES    (R1_TRIES)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .sector    (sector),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .errCode   (errCode),
    .bufRdEn   (bufRdEn),
    .bufAddr   (bufAddr),
    .bufRdData (bufRdData),
    .csN       (csN),
    .shCmd     (shCmd),
    .shDone    (shDone),
    .shRx      (shRx),
    .expired   (expired),
    .timerArm  (timerArm)
  );

  sdw_shifter #(.CLK_DIV(CLK_DIV)) i_shifter (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (shCmd),
    .miso   (miso),
    .sck    (sck),
    .mosi   (mosi),
    .active (shActive),
    .done   (shDone),
    .rxByte (shRx)
  );

  sdw_timer #(.LIMIT(TIMEOUT_CYCLES)) i_timer (
    .clk     (clk),
    .rstN    (rstN),
    .arm     (timerArm),
    .run     (busy),
    .expired (expired)
  );

  p_no_clock_when_deselected_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !shActive);

endmodule

// File: tb/test_sd_block_writer.sv
module test_sd_block_writer;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int TMO        = 20000;
  localparam int WORDS      = 128;

  logic        clk = 0, rstN = 0, start = 0;
  logic [31:0] sector = 0;
  logic        busy, done, error;
  logic [7:0]  errCode;
  logic        bufRdEn;
  logic [6:0]  bufAddr;
  logic [31:0] bufRdData = 0;
  logic        sck, mosi, csN;
  logic        miso = 1;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] misoQ[$];
  bit         sbEnable = 1, stuckLow = 0;
  logic [7:0] seed = 0;
  int         cycle = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_block_writer #(.CLK_DIV(DIV), .TIMEOUT_CYCLES(TMO)) i_sd_block_writer (
    .clk(clk), .rstN(rstN), .start(start), .sector(sector), .busy(busy),
    .done(done), .error(error), .errCode(errCode), .bufRdEn(bufRdEn),
    .bufAddr(bufAddr), .bufRdData(bufRdData), .sck(sck), .mosi(mosi),
    .miso(miso), .csN(csN));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] byteOf(int k);
    return 8'(k * 7) + seed;
  endfunction

  // sector buffer model: one-cycle read latency, little-endian words
  always @(posedge clk)
    if (bufRdEn)
      bufRdData <= {byteOf(bufAddr*4+3), byteOf(bufAddr*4+2), byteOf(bufAddr*4+1), byteOf(bufAddr*4)};

  // card model and scoreboard monitor, evaluated away from the active edge
  int         bitCnt = 0, gap = 0, tailRises = 0;
  logic [7:0] outSh = 8'hFF, inSh = 8'h00;
  logic       sckPrev = 1, mosiPrev = 1;
  always @(negedge clk) begin
    gap++;
    if (csN) begin
      bitCnt = 0;
      miso   = 1;
      if (!sckPrev && sck) tailRises++;
    end else begin
      tailRises = 0;
      if (sckPrev && !sck) begin
        if (bitCnt == 0) begin
          if (misoQ.size() > 0) outSh = misoQ.pop_front();
          else                  outSh = 8'hFF;
        end
        miso  = stuckLow ? 1'b0 : outSh[7];
        outSh = {outSh[6:0], 1'b1};
      end
      if (!sckPrev && sck) begin
        check(mosi == mosiPrev, "R2 mosi moved on rising sck", mosi, mosiPrev);
        if (bitCnt > 0) check(gap == DIV, "R2 sck period", gap, DIV);
        gap  = 0;
        inSh = {inSh[6:0], mosi};
        bitCnt++;
        if (bitCnt == 8) begin
          bitCnt = 0;
          if (sbEnable) begin
            if (expQ.size() == 0) check(0, "R6 unexpected byte on mosi", inSh, 0);
            else begin
              automatic logic [7:0] e = expQ.pop_front();
              automatic string t = tagQ.pop_front();
              check(inSh == e, t, inSh, e);
            end
          end
        end
      end
    end
    sckPrev  = sck;
    mosiPrev = mosi;
  end

  // watchdog
  always @(negedge clk) begin
    cycle++;
    if (cycle == 190000 && !finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic pushExp(input logic [7:0] b, input string tag);
    expQ.push_back(b);
    tagQ.push_back(tag);
  endtask

  task automatic pushCmd(input logic [31:0] s);
    pushExp(8'h58, "R4 cmd index");
    pushExp(s[31:24], "R4 arg byte 3");
    pushExp(s[23:16], "R4 arg byte 2");
    pushExp(s[15:8], "R4 arg byte 1");
    pushExp(s[7:0], "R4 arg byte 0");
    pushExp(8'h01, "R4 crc dummy");
    repeat (6) misoQ.push_back(8'hFF);
  endtask

  task automatic pushData();
    pushExp(8'hFE, "R6 start token");
    misoQ.push_back(8'hFF);
    for (int k = 0; k < WORDS*4; k++) begin
      pushExp(byteOf(k), "R6 data byte");
      misoQ.push_back(8'hFF);
    end
    pushExp(8'hFF, "R6 crc filler");
    pushExp(8'hFF, "R6 crc filler");
    misoQ.push_back(8'hFF);
    misoQ.push_back(8'hFF);
  endtask

  task automatic kick(input logic [31:0] s);
    @(negedge clk);
    sector = s;
    start  = 1;
    @(negedge clk);
    start  = 0;
    check(busy == 1'b1, "R1 busy after start", busy, 1);
    check(csN == 1'b0, "R1 cs low after start", csN, 0);
  endtask

  task automatic waitDone(output int cyc);
    cyc = 0;
    while (!done) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic endCheck(input bit expErr, input logic [7:0] expCode, input string tag);
    check(error == expErr, {tag, " error flag"}, error, expErr);
    check(errCode == expCode, {tag, " errCode"}, errCode, expCode);
    check(busy == 1'b0, "R9 busy falls with done", busy, 0);
    check(csN == 1'b1, "R9 cs high at done", csN, 1);
    check(tailRises == 8, "R9 tail clocks", tailRises, 8);
    check(expQ.size() == 0, {tag, " all expected bytes seen"}, expQ.size(), 0);
    @(negedge clk);
    check(done == 1'b0, "R9 done one cycle", done, 0);
    expQ.delete();
    tagQ.delete();
    misoQ.delete();
  endtask

  initial begin
    int cyc;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(csN == 1 && sck == 1 && mosi == 1, "R1 idle pins", {csN, sck, mosi}, 3'b111);
    check(busy == 0 && done == 0, "R1 idle handshake", {busy, done}, 0);

    // success: not ready once, R1 in second slot, busy for three bytes
    seed = 8'h03;
    pushExp(8'hFF, "R3 ready poll"); misoQ.push_back(8'h00);
    pushExp(8'hFF, "R3 ready poll"); misoQ.push_back(8'hFF);
    pushCmd(32'h12345678);
    pushExp(8'hFF, "R5 r1 slot"); misoQ.push_back(8'hFF);
    pushExp(8'hFF, "R5 r1 slot"); misoQ.push_back(8'h00);
    pushData();
    pushExp(8'hFF, "R7 response slot"); misoQ.push_back(8'hE5);
    for (int i = 0; i < 3; i++) begin
      pushExp(8'hFF, "R8 busy wait"); misoQ.push_back(8'h00);
    end
    pushExp(8'hFF, "R8 busy wait");
    kick(32'h12345678);
    repeat (3000) @(negedge clk);
    sector = 32'hDEADBEEF; start = 1;
    @(negedge clk);
    start = 0;
    check(busy == 1'b1, "R11 start ignored while busy", busy, 1);
    waitDone(cyc);
    endCheck(0, 8'h00, "R9 success");

    // nonzero R1
    pushExp(8'hFF, "R3 ready poll"); misoQ.push_back(8'hFF);
    pushCmd(32'h00000ABC);
    pushExp(8'hFF, "R5 r1 slot"); misoQ.push_back(8'h05);
    kick(32'h00000ABC);
    waitDone(cyc);
    endCheck(1, 8'h05, "R5 bad r1");

    // no R1 at all
    pushExp(8'hFF, "R3 ready poll"); misoQ.push_back(8'hFF);
    pushCmd(32'h80000001);
    for (int i = 0; i < 8; i++) pushExp(8'hFF, "R5 r1 slot");
    kick(32'h80000001);
    waitDone(cyc);
    endCheck(1, 8'h80, "R5 missing r1");

    // rejected data response
    seed = 8'h5A;
    pushExp(8'hFF, "R3 ready poll"); misoQ.push_back(8'hFF);
    pushCmd(32'h00000001);
    pushExp(8'hFF, "R5 r1 slot"); misoQ.push_back(8'h00);
    pushData();
    pushExp(8'hFF, "R7 response slot"); misoQ.push_back(8'hEB);
    kick(32'h00000001);
    waitDone(cyc);
    endCheck(1, 8'hAB, "R7 rejected data");

    // card stuck not ready: timeout
    sbEnable = 0;
    stuckLow = 1;
    kick(32'h00000002);
    waitDone(cyc);
    check(cyc + 2 >= TMO && cyc <= TMO + 300, "R10 timeout latency", cyc, TMO);
    endCheck(1, 8'hC0, "R10 timeout");
    stuckLow = 0;
    sbEnable = 1;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule